// File: doc/BRIEF.md
# Hierarchical Scan-Out Collection Tree

This block collects the observed value of one addressed storage cell out of a large array and delivers it to a single output pin. The cells are grouped in fours, and each group feeds a merge node. Every node receives a data bit and a "live" indication from each of its four children. It forwards the data of the one live child, together with the OR of the four live lines, to its parent. Nodes cascade level by level until a single root node drives the output. The address decoders that raise exactly one leaf's live line sit outside this block.

A parameter chooses whether each node ends in a flip-flop pair. Without the flip-flops the whole tree is one combinational path, and the result appears in the cycle the address is applied. With them each level costs one clock. A deep tree then meets timing, and a new cell can still be addressed on every cycle, because the readout is pipelined.

Top module: `scanout_tree`

## Requirements
- R1: When exactly one bit of `leafValid` is set, `outData` equals the `leafData` bit with the same index and `outValid` is 1, after the latency given in R5.
- R2: `outValid` is 1 whenever any leaf is live, also when the live leaf's data bit is 0, and in that case `outData` is 0.
- R3: When no bit of `leafValid` is set, `outValid` and `outData` are both 0, whatever `leafData` holds.
- R4: The `leafData` bits of leaves that are not live have no effect on `outData`.
- R5: With `REGISTERED`=1 the outputs at clock edge t+`LEVELS` reflect the leaf inputs sampled at edge t, and a different leaf may be addressed on every cycle. With `REGISTERED`=0 the outputs follow the inputs within the same cycle.
- R6: With `REGISTERED`=1, while `rstN` is low, `outValid` and `outData` are 0, whatever the leaf inputs hold.
- R7: Bit i of `leafValid` and `leafData` belongs to leaf i. First-level node k serves leaves 4k to 4k+3, and every leaf index from 0 to 4^`LEVELS`-1 can be observed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional node registers |
| rstN | input | 1 | Asynchronous active-low reset of the node registers |
| leafData | input | 4^LEVELS | Observed value of each cell, bit i for leaf i |
| leafValid | input | 4^LEVELS | Decoded live line of each cell, at most one set |
| outData | output | 1 | Data bit of the addressed cell at the root |
| outValid | output | 1 | High when some cell in the tree is addressed |

## Verification
The checker assumes that the decoders outside the block never raise more than one leaf live line in the same cycle, and it flags any cycle that breaks this rule. Its node-by-node merge checks hold only under that assumption. The stimulus applies either a single-bit `leafValid` built by shifting a 1 to the target index, or all zeros. The data pattern on the other leaves is free and is often random, which exercises the rule that those leaves are ignored. During reset the bench holds a one-hot live pattern, so the rule also holds there.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  // Children merged by every node of the tree.
  localparam int unsigned FANIN = 4;

  // Strobes the control half of a node hands to its datapath half.
  typedef struct packed {
    logic [FANIN-1:0] pick;     // one-hot choice of the child to forward
    logic             anyLive;  // some child holds the addressed cell
  } nodeStrobe_t;

  function automatic int unsigned powFan(input int unsigned exponent);
    int unsigned acc;
    acc = 1;
    for (int unsigned k = 0; k < exponent; k++) acc = acc * FANIN;
    return acc;
  endfunction

  // Index of the first link feeding level lvl in the flat link vector.
  // Level 0 links are the leaves; level `levels` is the single root link.
  function automatic int unsigned levelBase(input int unsigned levels,
                                            input int unsigned lvl);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < lvl; k++) acc = acc + powFan(levels - k);
    return acc;
  endfunction

endpackage

// File: rtl/scanout_node_ctrl.sv
module scanout_node_ctrl
  import scanout_pkg::*;
(
  input  logic [FANIN-1:0] childValid,
  output nodeStrobe_t      strobe
);

  // Isolate the lowest live child so the datapath always sees a one-hot
  // choice, even on an illegal multi-live input.
  assign strobe.pick    = childValid & (~childValid + FANIN'(1));
  assign strobe.anyLive = |childValid;

endmodule

// File: rtl/scanout_node_dp.sv
module scanout_node_dp
  import scanout_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FANIN-1:0] childData,
  input  nodeStrobe_t      strobe,
  output logic             parentData,
  output logic             parentValid
);

  logic mergedData;
  logic mergedValid;

  assign mergedData  = |(childData & strobe.pick);
  assign mergedValid = strobe.anyLive;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          parentData  <= 1'b0;
          parentValid <= 1'b0;
        end else begin
          parentData  <= mergedData;
          parentValid <= mergedValid;
        end
      end
    end else begin : g_comb
      logic unusedClkRst;
      assign unusedClkRst = clk & rstN;
      assign parentData   = mergedData;
      assign parentValid  = mergedValid;
    end
  endgenerate

endmodule

// File: rtl/scanout_tree.sv
module scanout_tree
  import scanout_pkg::*;
#(
  parameter int unsigned LEVELS     = 2,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned NUM_LEAVES = powFan(LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEAVES-1:0] leafData,
  input  logic [NUM_LEAVES-1:0] leafValid,
  output logic                  outData,
  output logic                  outValid
);

  localparam int unsigned ROOT_LINK   = levelBase(LEVELS, LEVELS);
  localparam int unsigned TOTAL_LINKS = ROOT_LINK + 1;

  logic [TOTAL_LINKS-1:0] linkData;
  logic [TOTAL_LINKS-1:0] linkValid;

  assign linkData[NUM_LEAVES-1:0]  = leafData;
  assign linkValid[NUM_LEAVES-1:0] = leafValid;

  generate
    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
      localparam int unsigned IN_BASE  = levelBase(LEVELS, lvl);
      localparam int unsigned OUT_BASE = levelBase(LEVELS, lvl + 1);
      localparam int unsigned NODES    = powFan(LEVELS - lvl - 1);
      for (genvar n = 0; n < NODES; n++) begin : g_node
        nodeStrobe_t nodeStb;

        scanout_node_ctrl u_ctrl (
          .childValid (linkValid[IN_BASE + n*FANIN +: FANIN]),
          .strobe     (nodeStb)
        );

        scanout_node_dp #(.REGISTERED(REGISTERED)) u_dp (
          .clk         (clk),
          .rstN        (rstN),
          .childData   (linkData[IN_BASE + n*FANIN +: FANIN]),
          .strobe      (nodeStb),
          .parentData  (linkData[OUT_BASE + n]),
          .parentValid (linkValid[OUT_BASE + n])
        );
      end
    end
  endgenerate

  assign outData  = linkData[ROOT_LINK];
  assign outValid = linkValid[ROOT_LINK];

endmodule

// File: rtl/scanout_tree_chk.sv
module scanout_tree_chk
  import scanout_pkg::*;
#(
  parameter int unsigned LEVELS      = 2,
  parameter bit          REGISTERED  = 1'b1,
  parameter int unsigned TOTAL_LINKS = 21
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [TOTAL_LINKS-1:0] linkData,
  input logic [TOTAL_LINKS-1:0] linkValid,
  input logic                   outData,
  input logic                   outValid
);

  localparam int unsigned NUM_LEAVES = powFan(LEVELS);

  logic primed;
  logic heldInReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  always_ff @(posedge clk) heldInReset <= !rstN;

  // input precondition: the decoders raise at most one leaf at a time
  single_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(linkValid[NUM_LEAVES-1:0]));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outData);

  generate
    if (REGISTERED) begin : g_regchk
      // R6
      reset_clear_chk: assert property (@(posedge clk)
        heldInReset && !rstN |-> !outValid && !outData);
    end

    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
      localparam int unsigned IN_BASE  = levelBase(LEVELS, lvl);
      localparam int unsigned OUT_BASE = levelBase(LEVELS, lvl + 1);
      localparam int unsigned NODES    = powFan(LEVELS - lvl - 1);
      for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int unsigned CHILD = IN_BASE + n*FANIN;
        if (REGISTERED) begin : g_r
          // R5
          node_valid_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
            primed |-> linkValid[OUT_BASE+n] == $past(|linkValid[CHILD +: FANIN]));
          // R1
          node_data_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
            primed && $past(|linkValid[CHILD +: FANIN]) |->
              linkData[OUT_BASE+n] == $past(|(linkValid[CHILD +: FANIN] & linkData[CHILD +: FANIN])));
        end else begin : g_c
          // R5
          node_valid_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
            linkValid[OUT_BASE+n] == |linkValid[CHILD +: FANIN]);
          // R4
          node_data_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
            linkData[OUT_BASE+n] == |(linkValid[CHILD +: FANIN] & linkData[CHILD +: FANIN]));
        end
      end
    end
  endgenerate

endmodule

bind scanout_tree scanout_tree_chk #(
  .LEVELS      (LEVELS),
  .REGISTERED  (REGISTERED),
  .TOTAL_LINKS (TOTAL_LINKS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .linkData  (linkData),
  .linkValid (linkValid),
  .outData   (outData),
  .outValid  (outValid)
);

// File: tb/scanout_tree_tb.sv
module scanout_tree_tb;
  import scanout_pkg::*;

  localparam int unsigned LEVELS = 2;
  localparam int unsigned LEAVES = powFan(LEVELS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [LEAVES-1:0] leafData = '0;
  logic [LEAVES-1:0] leafValid = '0;
  logic              outData, outValid, flatData, flatValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit monitorOn = 1'b0;

  bit    expD[$];
  bit    expV[$];
  string expTag[$];

  always #2 clk = ~clk;

  scanout_tree #(.LEVELS(LEVELS), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .leafData(leafData), .leafValid(leafValid),
    .outData(outData), .outValid(outValid));

  scanout_tree #(.LEVELS(LEVELS), .REGISTERED(1'b0)) u_dut_flat (
    .clk(clk), .rstN(rstN), .leafData(leafData), .leafValid(leafValid),
    .outData(flatData), .outValid(flatValid));

  task automatic check(input string tag, input bit actV, input bit actD,
                       input bit wantV, input bit wantD);
    testsRun++;
    if (actV !== wantV || actD !== wantD) begin
      testsFailed++;
      $display("FAIL %s: valid/data actual %0b/%0b expected %0b/%0b",
               tag, actV, actD, wantV, wantD);
    end
  endtask

  // Driver: apply one cycle of leaf inputs and push the expected root result.
  task automatic drive(input logic [LEAVES-1:0] v, input logic [LEAVES-1:0] d,
                       input string tag);
    bit wantV, wantD;
    @(negedge clk);
    leafValid = v;
    leafData  = d;
    wantV = |v;
    wantD = |(v & d);
    expV.push_back(wantV);
    expD.push_back(wantD);
    expTag.push_back(tag);
    monitorOn = 1'b1;
    #1 check({tag, " (flat, R5 same cycle)"}, flatValid, flatData, wantV, wantD);
  endtask

  // Monitor: the registered tree shows each item LEVELS edges after it was driven.
  always begin
    @(posedge clk);
    #1;
    if (monitorOn && expD.size() >= LEVELS) begin
      check({expTag[0], " (piped, R5 latency)"}, outValid, outData, expV[0], expD[0]);
      void'(expV.pop_front());
      void'(expD.pop_front());
      void'(expTag.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired, run incomplete (R1)");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R6: reset holds the registered root at zero despite a live leaf.
    leafValid = LEAVES'(1) << 5;
    leafData  = '1;
    repeat (3) @(negedge clk);
    #1 check("R6 reset clears outputs", outValid, outData, 1'b0, 1'b0);
    @(negedge clk);
    leafValid = '0;
    leafData  = '0;
    rstN = 1'b1;
    #1 check("R6 right after release", outValid, outData, 1'b0, 1'b0);

    // R1 / R7: every leaf index, both data polarities, back to back.
    for (int i = 0; i < int'(LEAVES); i++)
      drive(LEAVES'(1) << i, LEAVES'(32'hA5C3 ^ (i * 32'h1111)), "R7 leaf walk");
    for (int i = 0; i < int'(LEAVES); i++)
      drive(LEAVES'(1) << i, ~LEAVES'(32'hA5C3 ^ (i * 32'h1111)), "R1 leaf walk inverted");

    // R2: a live leaf whose data is 0 still raises valid.
    drive(LEAVES'(1) << 0, '0, "R2 live zero");
    drive(LEAVES'(1) << (LEAVES-1), ~(LEAVES'(1) << (LEAVES-1)), "R2 live zero, others high");

    // R4: the live leaf 9 is fixed, the other leaves change every cycle.
    for (int k = 0; k < 6; k++)
      drive(LEAVES'(1) << 9, LEAVES'($urandom()) | (LEAVES'(1) << 9), "R4 others toggle, live 1");
    for (int k = 0; k < 6; k++)
      drive(LEAVES'(1) << 9, LEAVES'($urandom()) & ~(LEAVES'(1) << 9), "R4 others toggle, live 0");

    // R3: nothing addressed, data noise on all leaves.
    for (int k = 0; k < 5; k++)
      drive('0, LEAVES'($urandom()), "R3 idle with noise");
    drive('0, '1, "R3 idle all ones");

    // R5: alternate addresses in separate subtrees every cycle.
    for (int k = 0; k < 8; k++)
      drive(LEAVES'(1) << ((k % 2 == 0) ? 3 : 12),
            (k % 4 < 2) ? LEAVES'(16'h1008) : LEAVES'(16'h0000), "R5 alternating address");

    // Drain the pipeline with idle cycles.
    for (int k = 0; k <= int'(LEVELS); k++)
      drive('0, '0, "R3 drain");
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule